// File: doc/BRIEF.md
# High-Speed Counter Compare Unit

The unit holds a 32-bit up/down pulse counter and a table of six compare slots that watch it. Each slot is configured through a small write port. Each slot is off, in set mode, in reset mode or in zone mode.

A set slot drives its output high when a count step lands on its compare value. A reset slot drives it low on the same event. A zone slot drives three level flags from a lower and an upper limit. A set or reset slot may instead pulse an interrupt request line when it matches. Every result changes on the same clock edge as the count that causes it, so nothing waits for a software scan.

The counter can also be loaded directly. A load never counts as a match event. This lets software reposition the counter without firing the slots.

The configuration port is a plain write strobe with no ready signal. It is accepted in every cycle and never applies back-pressure. The count strobes, load and clear are plain control pins that act on the next rising edge.

Top module: `hsc_cmp_unit`

## Requirements
- R1: After reset the count is 0, every slot is off, and all of `hit`, `irq`, the zone flags and `wr_err` are low.
- R2: On a cycle with no load, a lone `cnt_up` adds 1 and a lone `cnt_dn` subtracts 1, modulo 2^32. When both are high together the count is unchanged.
- R3: `ld_en` replaces the count with `ld_val` at the next edge and takes priority over both strobes.
- R4: A set slot (mode code 1) raises `hit[i]` on the edge where a count step makes the count equal its compare value (`cfg_lo`). This applies whether the count steps up from value-1 or down from value+1. `hit[i]` then holds.
- R5: A reset slot (mode code 2) drives `hit[i]` low on the same kind of step-into-equality event. Otherwise `hit[i]` holds.
- R6: A load whose value equals a slot's compare value changes neither `hit` nor `irq`.
- R7: A zone slot (mode code 3) drives exactly one of three flags, following the current count at all times. `zone_lo[i]` is high when count < lower, `zone_in[i]` when lower <= count <= upper, and `zone_hi[i]` when count > upper. A slot that is not in zone mode holds all three flags low.
- R8: A zone write with lower > upper is rejected, leaving the slot unchanged, and sets the sticky bit `wr_err`.
- R9: A set or reset slot written with `cfg_irq`=1 gives a one-cycle `irq[i]` pulse on a match instead of changing `hit[i]`.
- R10: `clr` drives all `hit` bits and `wr_err` low at the next edge and wins over a match in the same cycle.
- R11: `cfg_we` writes slot `cfg_idx` (mode 0 off, 1 set, 2 reset, 3 zone) effective from the next edge. An index of 6 or more is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_up | input | 1 | Count-up strobe |
| cnt_dn | input | 1 | Count-down strobe |
| ld_en | input | 1 | Direct load enable |
| ld_val | input | 32 | Load value |
| clr | input | 1 | Synchronous clear of hit outputs and error bit |
| cfg_we | input | 1 | Slot write strobe |
| cfg_idx | input | 3 | Slot index |
| cfg_mode | input | 2 | Slot mode code |
| cfg_irq | input | 1 | Route a match to the interrupt line |
| cfg_lo | input | 32 | Compare value, or lower zone limit |
| cfg_hi | input | 32 | Upper zone limit |
| count | output | 32 | Current count |
| hit | output | 6 | Set/reset outputs, one per slot |
| irq | output | 6 | Interrupt request pulses, one per slot |
| zone_lo | output | 6 | Zone flag: below the lower limit |
| zone_in | output | 6 | Zone flag: within the limits |
| zone_hi | output | 6 | Zone flag: above the upper limit |
| wr_err | output | 1 | Sticky rejected-write flag |

## Verification
Two pairs of functions can fall in the same cycle. The first is a load and a count step. The bench raises `ld_en` with `cnt_up` and expects the loaded value and no match, even when the stepped value would have matched. The second is a clear and a step into equality. The bench loads value-1 and then asserts `clr` together with `cnt_up`, and judges that the count reaches the compare value while `hit` stays low.

// File: rtl/hsc_cmp_pkg.sv
package hsc_cmp_pkg;
  localparam int CNT_W = 32;
  localparam int N_ENT = 6;

  typedef enum logic [1:0] {
    M_OFF  = 2'd0,
    M_SET  = 2'd1,
    M_RST  = 2'd2,
    M_ZONE = 2'd3
  } slot_mode_t;

  typedef struct packed {
    slot_mode_t        mode;
    logic              irq_en;
    logic [CNT_W-1:0]  lo;
    logic [CNT_W-1:0]  hi;
  } slot_cfg_t;
endpackage

// File: rtl/hsc_counter.sv
module hsc_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         up,
  input  logic         dn,
  input  logic         ld_en,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] cnt_nx,
  output logic         step_ev
);
  always_comb begin
    if (ld_en)          cnt_nx = ld_val;
    else if (up && !dn) cnt_nx = cnt_q + 1'b1;
    else if (dn && !up) cnt_nx = cnt_q - 1'b1;
    else                cnt_nx = cnt_q;
  end

  assign step_ev = !ld_en && (up ^ dn);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nx;
  end

  a_r2_count_up: assert property (@(posedge clk) disable iff (!rst_n)
    (up && !dn && !ld_en) |=> (cnt_q == $past(cnt_q) + 1'b1));
  a_r2_cancel: assert property (@(posedge clk) disable iff (!rst_n)
    (up && dn && !ld_en) |=> $stable(cnt_q));
  a_r3_load: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |=> (cnt_q == $past(ld_val)));
endmodule

// File: rtl/hsc_entry_table.sv
module hsc_entry_table
  import hsc_cmp_pkg::*;
#(
  parameter int N = 6,
  parameter int W = 32,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          we,
  input  logic [IW-1:0] idx,
  input  logic [1:0]    mode,
  input  logic          irq_en,
  input  logic [W-1:0]  lo,
  input  logic [W-1:0]  hi,
  output slot_cfg_t     cfg [N],
  output logic          err
);
  logic idx_ok;
  logic bad_zone;

  assign idx_ok   = int'(idx) < N;
  assign bad_zone = (slot_mode_t'(mode) == M_ZONE) && (lo > hi);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) cfg[i] <= '{mode: M_OFF, irq_en: 1'b0, lo: '0, hi: '0};
      err <= 1'b0;
    end else begin
      if (we && idx_ok && !bad_zone)
        cfg[idx] <= '{mode: slot_mode_t'(mode), irq_en: irq_en, lo: lo, hi: hi};
      if (clr)
        err <= 1'b0;
      else if (we && idx_ok && bad_zone)
        err <= 1'b1;
    end
  end

  a_r8_reject_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (we && idx_ok && bad_zone && !clr) |=> err);
endmodule

// File: rtl/hsc_cmp_slot.sv
module hsc_cmp_slot
  import hsc_cmp_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         step_ev,
  input  logic [W-1:0] cnt_nx,
  input  logic [W-1:0] cnt_q,
  input  slot_cfg_t    cfg,
  output logic         hit,
  output logic         irq,
  output logic         z_lo,
  output logic         z_in,
  output logic         z_hi
);
  logic match_ev;
  logic is_sr;
  logic is_zone;

  assign is_sr    = (cfg.mode == M_SET) || (cfg.mode == M_RST);
  assign is_zone  = cfg.mode == M_ZONE;
  assign match_ev = step_ev && is_sr && (cnt_nx == cfg.lo);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit <= 1'b0;
      irq <= 1'b0;
    end else begin
      irq <= match_ev && cfg.irq_en;
      if (clr)
        hit <= 1'b0;
      else if (match_ev && !cfg.irq_en)
        hit <= (cfg.mode == M_SET);
    end
  end

  always_comb begin
    z_lo = is_zone && (cnt_q < cfg.lo);
    z_hi = is_zone && (cnt_q > cfg.hi);
    z_in = is_zone && !(cnt_q < cfg.lo) && !(cnt_q > cfg.hi);
  end

  a_r7_zone_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    is_zone |-> ($countones({z_lo, z_in, z_hi}) == 1));
  a_r10_clr_wins: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !hit);
  a_r9_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq || $past(step_ev));
endmodule

// File: rtl/hsc_cmp_unit.sv
module hsc_cmp_unit
  import hsc_cmp_pkg::*;
#(
  parameter int W = CNT_W,
  parameter int N = N_ENT,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cnt_up,
  input  logic          cnt_dn,
  input  logic          ld_en,
  input  logic [W-1:0]  ld_val,
  input  logic          clr,
  input  logic          cfg_we,
  input  logic [IW-1:0] cfg_idx,
  input  logic [1:0]    cfg_mode,
  input  logic          cfg_irq,
  input  logic [W-1:0]  cfg_lo,
  input  logic [W-1:0]  cfg_hi,
  output logic [W-1:0]  count,
  output logic [N-1:0]  hit,
  output logic [N-1:0]  irq,
  output logic [N-1:0]  zone_lo,
  output logic [N-1:0]  zone_in,
  output logic [N-1:0]  zone_hi,
  output logic          wr_err
);
  logic [W-1:0] cnt_nx;
  logic         step_ev;
  slot_cfg_t    cfg [N];

  hsc_counter #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .up(cnt_up), .dn(cnt_dn),
    .ld_en(ld_en), .ld_val(ld_val),
    .cnt_q(count), .cnt_nx(cnt_nx), .step_ev(step_ev)
  );

  hsc_entry_table #(.N(N), .W(W)) u_tab (
    .clk(clk), .rst_n(rst_n), .clr(clr), .we(cfg_we), .idx(cfg_idx),
    .mode(cfg_mode), .irq_en(cfg_irq), .lo(cfg_lo), .hi(cfg_hi),
    .cfg(cfg), .err(wr_err)
  );

  for (genvar g = 0; g < N; g++) begin : g_slot
    hsc_cmp_slot #(.W(W)) u_slot (
      .clk(clk), .rst_n(rst_n), .clr(clr), .step_ev(step_ev),
      .cnt_nx(cnt_nx), .cnt_q(count), .cfg(cfg[g]),
      .hit(hit[g]), .irq(irq[g]),
      .z_lo(zone_lo[g]), .z_in(zone_in[g]), .z_hi(zone_hi[g])
    );
  end

  a_r6_load_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en && !clr) |=> ($stable(hit) && (irq == '0)));
endmodule

// File: tb/hsc_cmp_unit_test.sv
module hsc_cmp_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_up = 0, cnt_dn = 0, ld_en = 0, clr = 0;
  logic [31:0] ld_val = '0;
  logic        cfg_we = 0, cfg_irq = 0;
  logic [2:0]  cfg_idx = '0;
  logic [1:0]  cfg_mode = '0;
  logic [31:0] cfg_lo = '0, cfg_hi = '0;
  logic [31:0] count;
  logic [5:0]  hit, irq, zone_lo, zone_in, zone_hi;
  logic        wr_err;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  hsc_cmp_unit uut (
    .clk(clk), .rst_n(rst_n), .cnt_up(cnt_up), .cnt_dn(cnt_dn),
    .ld_en(ld_en), .ld_val(ld_val), .clr(clr), .cfg_we(cfg_we),
    .cfg_idx(cfg_idx), .cfg_mode(cfg_mode), .cfg_irq(cfg_irq),
    .cfg_lo(cfg_lo), .cfg_hi(cfg_hi), .count(count), .hit(hit),
    .irq(irq), .zone_lo(zone_lo), .zone_in(zone_in), .zone_hi(zone_hi),
    .wr_err(wr_err)
  );

  // {up, dn, ld, load value, expected count}
  localparam logic [66:0] VECS [8] = '{
    {1'b0, 1'b0, 1'b1, 32'd100,        32'd100},
    {1'b1, 1'b0, 1'b0, 32'd0,          32'd101},
    {1'b0, 1'b1, 1'b0, 32'd0,          32'd100},
    {1'b1, 1'b1, 1'b0, 32'd0,          32'd100},
    {1'b0, 1'b0, 1'b1, 32'hFFFF_FFFF,  32'hFFFF_FFFF},
    {1'b1, 1'b0, 1'b0, 32'd0,          32'd0},
    {1'b0, 1'b1, 1'b0, 32'd0,          32'hFFFF_FFFF},
    {1'b1, 1'b0, 1'b1, 32'd5,          32'd5}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic u, input logic d, input logic l, input logic [31:0] v,
                       input logic c);
    cnt_up = u; cnt_dn = d; ld_en = l; ld_val = v; clr = c;
    @(negedge clk);
    cnt_up = 0; cnt_dn = 0; ld_en = 0; clr = 0;
  endtask

  task automatic wr(input int idx, input logic [1:0] m, input logic q,
                    input logic [31:0] lo, input logic [31:0] hi);
    cfg_we = 1; cfg_idx = 3'(idx); cfg_mode = m; cfg_irq = q; cfg_lo = lo; cfg_hi = hi;
    @(negedge clk);
    cfg_we = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 count", count, 32'd0);
    chk("R1 hit", {26'd0, hit}, 32'd0);
    chk("R1 irq", {26'd0, irq}, 32'd0);
    chk("R1 zone", {14'd0, zone_lo, zone_in, zone_hi}, 32'd0);
    chk("R1 wr_err", {31'd0, wr_err}, 32'd0);

    for (int i = 0; i < 8; i++) begin
      logic [66:0] v;
      v = VECS[i];
      drive(v[66], v[65], v[64], v[63:32], 1'b0);
      chk(v[64] ? "R3 load vector" : "R2 step vector", count, v[31:0]);
    end

    // R4 set mode, upward approach
    wr(0, 2'd1, 1'b0, 32'd200, 32'd0);
    drive(0, 0, 1, 32'd198, 0);
    drive(1, 0, 0, 0, 0);
    chk("R4 before match", {31'd0, hit[0]}, 32'd0);
    drive(1, 0, 0, 0, 0);
    chk("R4 up match", {31'd0, hit[0]}, 32'd1);
    // R11 out-of-range index ignored: slot 0 stays set mode
    wr(7, 2'd2, 1'b0, 32'd201, 32'd0);
    drive(1, 0, 0, 0, 0);
    chk("R11 bad index ignored", {31'd0, hit[0]}, 32'd1);

    // R6 load onto compare value, then R4 downward approach
    wr(1, 2'd1, 1'b0, 32'd50, 32'd0);
    drive(0, 0, 1, 32'd50, 0);
    chk("R6 load no hit", {31'd0, hit[1]}, 32'd0);
    chk("R6 load no irq", {26'd0, irq}, 32'd0);
    drive(1, 0, 0, 0, 0);
    drive(0, 1, 0, 0, 0);
    chk("R4 down match", {31'd0, hit[1]}, 32'd1);
    // R3 load beats a step that would match
    wr(3, 2'd1, 1'b0, 32'd51, 32'd0);
    drive(1, 0, 1, 32'd7, 0);
    chk("R3 load over step count", count, 32'd7);
    chk("R3 load over step no hit", {31'd0, hit[3]}, 32'd0);

    // R5 reset mode
    wr(2, 2'd1, 1'b0, 32'd60, 32'd0);
    drive(0, 0, 1, 32'd59, 0);
    drive(1, 0, 0, 0, 0);
    chk("R5 armed high", {31'd0, hit[2]}, 32'd1);
    wr(2, 2'd2, 1'b0, 32'd62, 32'd0);
    drive(1, 0, 0, 0, 0);
    chk("R5 holds off match", {31'd0, hit[2]}, 32'd1);
    drive(1, 0, 0, 0, 0);
    chk("R5 reset on match", {31'd0, hit[2]}, 32'd0);

    // R9 interrupt routing
    wr(4, 2'd1, 1'b1, 32'd70, 32'd0);
    drive(0, 0, 1, 32'd69, 0);
    drive(1, 0, 0, 0, 0);
    chk("R9 irq pulse", {26'd0, irq}, 32'h10);
    chk("R9 hit untouched", {31'd0, hit[4]}, 32'd0);
    @(negedge clk);
    chk("R9 irq one cycle", {26'd0, irq}, 32'd0);

    // R7 zone flags
    wr(5, 2'd3, 1'b0, 32'd10, 32'd20);
    drive(0, 0, 1, 32'd5, 0);
    chk("R7 below", {29'd0, zone_lo[5], zone_in[5], zone_hi[5]}, 32'b100);
    drive(0, 0, 1, 32'd10, 0);
    chk("R7 at lower", {29'd0, zone_lo[5], zone_in[5], zone_hi[5]}, 32'b010);
    drive(0, 0, 1, 32'd20, 0);
    chk("R7 at upper", {29'd0, zone_lo[5], zone_in[5], zone_hi[5]}, 32'b010);
    drive(1, 0, 0, 0, 0);
    chk("R7 above", {29'd0, zone_lo[5], zone_in[5], zone_hi[5]}, 32'b001);
    chk("R7 non-zone slot low", {29'd0, zone_lo[0], zone_in[0], zone_hi[0]}, 32'd0);

    // R8 rejected zone write
    wr(5, 2'd3, 1'b0, 32'd30, 32'd25);
    chk("R8 wr_err set", {31'd0, wr_err}, 32'd1);
    chk("R8 slot unchanged", {29'd0, zone_lo[5], zone_in[5], zone_hi[5]}, 32'b001);

    // R10 clear, then clear against a same-cycle match
    drive(0, 0, 0, 0, 1);
    chk("R10 hit cleared", {26'd0, hit}, 32'd0);
    chk("R10 wr_err cleared", {31'd0, wr_err}, 32'd0);
    drive(0, 0, 1, 32'd49, 0);
    drive(1, 0, 0, 0, 1);
    chk("R10 clr wins count", count, 32'd50);
    chk("R10 clr wins hit", {31'd0, hit[1]}, 32'd0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule